// File: doc/BRIEF.md
# Residence Time Correction Updater

This block sits on the egress byte path of a switch port. It edits, in a single pass, frames that upstream parsing has marked as precision-time event messages carried over UDP/IPv4. Each frame arrives as a byte stream that starts at the first byte after the start-of-frame delimiter and ends with the four frame check sequence bytes. The block holds every byte for a fixed number of cycles. While the frame moves through that delay, the block works out how long the frame stayed in the switch. It takes the egress timestamp minus the ingress timestamp. Both timestamps come from one free-running counter that ticks on both edges of a 100 MHz clock, so one count is 5 ns.

The residence time is added to the 64-bit correction field, whose unit is nanoseconds scaled by 2^16. The UDP checksum is patched incrementally and the CRC-32 is recomputed, so the frame that leaves is still valid. Frames that arrive with the modify flag low pass through with no change at all, including their original FCS. The byte positions of the correction field and of the checksum are inputs, so the block does not depend on VLAN tagging or on the IP header length.

Top module: `rtc_updater`

## Requirements
- R1: Every accepted input byte, together with its start and end marks, appears on the output registered on the DEPTH-th rising edge after the edge that accepted it. Every byte that is not patched keeps its value, and a frame that is contiguous at the input is contiguous at the output.
- R2: The ingress timestamp is sampled with the first byte of the input frame. The egress timestamp is sampled on the edge that raises the output start mark. The value added is ((egress - ingress) mod 2^TS_W) * 5 * 2^16.
- R3: The 8 bytes at corr_off, read most significant byte first, leave as the old value plus the added value, modulo 2^64.
- R4: An egress timestamp that has wrapped below the ingress timestamp still gives the small positive difference.
- R5: The 2 bytes at csum_off, most significant first, leave as ~(~HC + sum of ~old words + sum of new words) in one's-complement arithmetic, summed over the four 16-bit words of the correction field. A result of 0x0000 is sent as 0xFFFF.
- R6: A received checksum of 0x0000 leaves as 0x0000.
- R7: In a patched frame, the last 4 bytes are replaced by a CRC-32 over all earlier output bytes. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, is inverted at the end and is sent least significant byte first.
- R8: The modify flag is sampled with the first input byte. When it is low, every output byte of the frame, including the FCS, equals the input byte.
- R9: Two frames may follow each other with no idle cycle. Each then uses its own timestamps and fields, provided that every frame is at least DEPTH bytes long, that 1 <= csum_off < corr_off, and that corr_off + 8 <= DEPTH.
- R10: While reset is held, and after it until a frame arrives, the output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | First byte after the SFD |
| in_eof | input | 1 | Last FCS byte |
| in_data | input | 8 | Input byte |
| in_mod | input | 1 | Patch this frame (event frame received without error), sampled with in_sof |
| in_rx_ts | input | TS_W | Ingress timestamp in half-cycles, sampled with in_sof |
| tx_ts | input | TS_W | Egress timestamp in half-cycles, sampled as the frame starts leaving |
| cfg_corr_off | input | POS_W | Byte position of the correction field |
| cfg_csum_off | input | POS_W | Byte position of the UDP checksum |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_data | output | 8 | Output byte |

## Verification
The bench targets four cases: a timestamp difference that wraps, a correction sum that carries across bytes and overflows 64 bits, a received checksum of zero, and frames that follow each other with no gap. Getting the wrap wrong would add a value near 2^TS_W. Dropping a carry would corrupt the upper correction bytes. Patching a zero checksum would hand the receiver a checksum it should never have seen. A design that lets the next frame's timestamp or checksum overwrite the current frame's values would emit the wrong correction or checksum on the first frame. An unmodified frame with a deliberately bad FCS checks that pass-through never recomputes the CRC.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       mod;
    logic       eof;
    logic       sof;
    logic       valid;
    logic [7:0] data;
  } beat_t;

  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  // R2: half-cycle difference to scaled nanoseconds (5 ns per count, 2^16 scale)
  function automatic logic [63:0] resid_scaled(input logic [63:0] half_cycles);
    return (half_cycles * 64'd5) << 16;
  endfunction

  // R7: one byte of reflected CRC-32
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction

  // R5, R6: incremental one's-complement checksum update over four words
  function automatic logic [15:0] csum_patch(input logic [15:0] hc,
                                             input logic [63:0] m_old,
                                             input logic [63:0] m_new);
    logic [19:0] acc;
    logic [15:0] r;
    acc = {4'h0, ~hc};
    for (int i = 0; i < 4; i++)
      acc = acc + {4'h0, ~m_old[16*i +: 16]} + {4'h0, m_new[16*i +: 16]};
    acc = {4'h0, acc[15:0]} + {16'h0, acc[19:16]};
    acc = {4'h0, acc[15:0]} + {16'h0, acc[19:16]};
    r = ~acc[15:0];
    if (hc == 16'h0)      r = 16'h0;
    else if (r == 16'h0)  r = 16'hFFFF;
    return r;
  endfunction

endpackage

// File: rtl/rtc_in_track.sv
module rtc_in_track
  import rtc_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic [TS_W-1:0]  in_rx_ts,
  input  logic [POS_W-1:0] cfg_corr_off,
  input  logic [POS_W-1:0] cfg_csum_off,
  output logic [TS_W-1:0]  rx_hold,
  output logic [63:0]      corr_old,
  output logic [15:0]      hc_old
);
  logic [POS_W-1:0] in_cnt, in_pos, rel_c;
  logic             hit_corr;

  assign in_pos   = in_sof ? '0 : in_cnt;
  assign rel_c    = in_pos - cfg_corr_off;
  assign hit_corr = (in_pos >= cfg_corr_off) && (rel_c < POS_W'(8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt   <= '0;
      rx_hold  <= '0;
      corr_old <= '0;
      hc_old   <= '0;
    end else if (in_valid) begin
      in_cnt <= in_pos + POS_W'(1);
      if (in_sof) rx_hold <= in_rx_ts;                           // R2
      if (hit_corr) corr_old[{~rel_c[2:0], 3'b000} +: 8] <= in_data; // R3
      if (in_pos == cfg_csum_off) hc_old[15:8] <= in_data;       // R5
      if (in_pos == cfg_csum_off + POS_W'(1)) hc_old[7:0] <= in_data;
    end
  end
endmodule

// File: rtl/rtc_delay.sv
module rtc_delay
  import rtc_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  beat_t      d,
  output beat_t      q,
  output logic [3:0] tail_eof
);
  beat_t stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[g] <= '0;
      else if (g == 0) stg[g] <= d;
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  for (genvar n = 0; n < 4; n++) begin : g_tail
    assign tail_eof[n] = stg[DEPTH-1-n].valid & stg[DEPTH-1-n].eof;
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/rtc_out_edit.sv
module rtc_out_edit
  import rtc_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  beat_t            cur,
  input  logic [3:0]       tail_eof,
  input  logic [TS_W-1:0]  tx_ts,
  input  logic [TS_W-1:0]  rx_hold,
  input  logic [63:0]      corr_old,
  input  logic [15:0]      hc_old,
  input  logic [POS_W-1:0] cfg_corr_off,
  input  logic [POS_W-1:0] cfg_csum_off,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [7:0]       out_data,
  output logic             sel_corr,
  output logic             sel_csum,
  output logic             sel_fcs,
  output logic             patch_ready,
  output logic             hc_zero
);
  logic [POS_W-1:0] pos_cnt, cur_pos, rel_c;
  logic [63:0]      corr_new, corr_base;
  logic [15:0]      hc_base, csum_new;
  logic [31:0]      crc;
  logic [TS_W-1:0]  dts;
  logic [1:0]       fcs_idx;
  logic             fcs_hit;
  logic [7:0]       edit_byte;

  assign cur_pos  = cur.sof ? '0 : pos_cnt;
  assign rel_c    = cur_pos - cfg_corr_off;
  assign dts      = tx_ts - rx_hold;                              // R4 modular
  assign csum_new = csum_patch(hc_base, corr_base, corr_new);    // R5
  assign hc_zero  = (hc_base == 16'h0);

  always_comb begin
    fcs_hit = 1'b0;
    fcs_idx = 2'd0;
    for (int n = 0; n < 4; n++)
      if (tail_eof[n]) begin
        fcs_hit = 1'b1;
        fcs_idx = 2'(3 - n);
      end
  end

  assign sel_fcs  = cur.valid & cur.mod & fcs_hit;
  assign sel_corr = cur.valid & cur.mod & (cur_pos >= cfg_corr_off) & (rel_c < POS_W'(8));
  assign sel_csum = cur.valid & cur.mod &
                    ((cur_pos == cfg_csum_off) | (cur_pos == cfg_csum_off + POS_W'(1)));

  always_comb begin
    if (sel_fcs)       edit_byte = ~crc[{fcs_idx, 3'b000} +: 8];          // R7
    else if (sel_corr) edit_byte = corr_new[{~rel_c[2:0], 3'b000} +: 8];  // R3
    else if (sel_csum) edit_byte = (cur_pos == cfg_csum_off) ? csum_new[15:8]
                                                             : csum_new[7:0];
    else               edit_byte = cur.data;                              // R1, R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_cnt     <= '0;
      corr_new    <= '0;
      corr_base   <= '0;
      hc_base     <= '0;
      patch_ready <= 1'b0;
      crc         <= '1;
      out_valid   <= 1'b0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid <= cur.valid;                                    // R10
      out_sof   <= cur.valid & cur.sof;
      out_eof   <= cur.valid & cur.eof;
      out_data  <= edit_byte;
      if (cur.valid) begin
        pos_cnt <= cur_pos + POS_W'(1);
        if (cur.sof) begin                                       // R2, R9 snapshot
          corr_new    <= corr_old + resid_scaled(64'(dts));
          corr_base   <= corr_old;
          hc_base     <= hc_old;
          patch_ready <= 1'b1;
        end else if (cur.eof) begin
          patch_ready <= 1'b0;
        end
        if (!fcs_hit) crc <= crc32_byte(cur.sof ? 32'hFFFF_FFFF : crc, edit_byte);
      end
    end
  end
endmodule

// File: rtl/rtc_updater.sv
module rtc_updater
  import rtc_pkg::*;
#(
  parameter int TS_W    = 32,
  parameter int MAX_LEN = 2048,
  parameter int DEPTH   = 64,
  localparam int POS_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic             in_mod,
  input  logic [TS_W-1:0]  in_rx_ts,
  input  logic [TS_W-1:0]  tx_ts,
  input  logic [POS_W-1:0] cfg_corr_off,
  input  logic [POS_W-1:0] cfg_csum_off,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [7:0]       out_data
);
  logic [TS_W-1:0] rx_hold;
  logic [63:0]     corr_old;
  logic [15:0]     hc_old;
  logic            mod_hold, mod_cur;
  beat_t           beat_in, cur;
  logic [3:0]      tail_eof;
  logic            sel_corr, sel_csum, sel_fcs, patch_ready, hc_zero;
  logic            cur_valid, cur_sof, cur_mod;
  logic [7:0]      cur_data;

  assign mod_cur = in_sof ? in_mod : mod_hold;                   // R8
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mod_hold <= 1'b0;
    else if (in_valid && in_sof) mod_hold <= in_mod;
  end

  assign beat_in = in_valid ? '{mod: mod_cur, eof: in_eof, sof: in_sof, valid: 1'b1, data: in_data}
                            : '0;

  rtc_in_track #(.TS_W(TS_W), .POS_W(POS_W)) u_in (
    .clk, .rst_n, .in_valid, .in_sof, .in_data, .in_rx_ts,
    .cfg_corr_off, .cfg_csum_off, .rx_hold, .corr_old, .hc_old
  );

  rtc_delay #(.DEPTH(DEPTH)) u_dly (
    .clk, .rst_n, .d(beat_in), .q(cur), .tail_eof
  );

  rtc_out_edit #(.TS_W(TS_W), .POS_W(POS_W)) u_edit (
    .clk, .rst_n, .cur, .tail_eof, .tx_ts, .rx_hold, .corr_old, .hc_old,
    .cfg_corr_off, .cfg_csum_off, .out_valid, .out_sof, .out_eof, .out_data,
    .sel_corr, .sel_csum, .sel_fcs, .patch_ready, .hc_zero
  );

  assign cur_valid = cur.valid;
  assign cur_sof   = cur.sof;
  assign cur_mod   = cur.mod;
  assign cur_data  = cur.data;
endmodule

// File: rtl/rtc_updater_chk.sv
module rtc_updater_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_eof,
  input logic [7:0] out_data,
  input logic       cur_valid,
  input logic       cur_sof,
  input logic       cur_mod,
  input logic [7:0] cur_data,
  input logic       sel_corr,
  input logic       sel_csum,
  input logic       sel_fcs,
  input logic       patch_ready,
  input logic       hc_zero
);
  AST_PASS_UNMODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && !cur_mod) |=> (out_valid && out_data == $past(cur_data))); // R8
  AST_SOF_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && cur_sof) |=> (out_valid && out_sof)); // R1
  AST_OUT_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |=> out_valid); // R1
  AST_FIELDS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_corr, sel_csum, sel_fcs})); // R9
  AST_PATCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_corr || sel_csum) |-> patch_ready); // R3
  AST_ZERO_CSUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_csum && hc_zero) |=> (out_data == 8'h00)); // R6
endmodule

bind rtc_updater rtc_updater_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sof(out_sof),
  .out_eof(out_eof), .out_data(out_data), .cur_valid(cur_valid),
  .cur_sof(cur_sof), .cur_mod(cur_mod), .cur_data(cur_data),
  .sel_corr(sel_corr), .sel_csum(sel_csum), .sel_fcs(sel_fcs),
  .patch_ready(patch_ready), .hc_zero(hc_zero)
);

// File: tb/sim_rtc_updater.sv
module sim_rtc_updater;
  localparam int DEPTH = 64;
  localparam int FLEN  = 64;
  localparam int CORR  = 50;
  localparam int CSUM  = 40;

  typedef struct packed {
    logic [31:0] rx;
    logic [31:0] tx;
    logic [63:0] corr;
    logic [15:0] hc;
    logic        mod;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'd1000,       32'd1200,   64'h0,                   16'h1234, 1'b1},
    '{32'hFFFF_FFF0,  32'd16,     64'h0000_0001_0000_0000, 16'hABCD, 1'b1},
    '{32'd5,          32'd400005, 64'h0000_0000_FFFF_8000, 16'h0000, 1'b1},
    '{32'd77,         32'd99,     64'hFFFF_FFFF_FFFF_0000, 16'h0001, 1'b1},
    '{32'd10,         32'd5000,   64'h1234_5678_9ABC_DEF0, 16'hBEEF, 1'b0},
    '{32'd42,         32'd42,     64'h0102_0304_0506_0708, 16'h5A5A, 1'b1}
  };

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0, in_mod = 0;
  logic [7:0]  in_data = 0;
  logic [31:0] in_rx_ts = 0, tx_ts = 0;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;

  int n_chk = 0, n_fail = 0, cyc = 0, fo_cnt = 0, fo_k = 0, cyc_in = 0, cyc_out = 0;
  logic [7:0] fin  [2][FLEN];
  logic [7:0] fexp [2][FLEN];
  logic [7:0] fout [2][FLEN];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_updater u0 (
    .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data, .in_mod, .in_rx_ts, .tx_ts,
    .cfg_corr_off(11'(CORR)), .cfg_csum_off(11'(CSUM)),
    .out_valid, .out_sof, .out_eof, .out_data
  );

  always @(negedge clk) if (rst_n && out_valid) begin
    if (out_sof) begin fo_k = 0; fo_cnt++; cyc_out = cyc; end
    fout[(fo_cnt - 1) % 2][fo_k % FLEN] = out_data;
    fo_k++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bench_crc(input logic [7:0] b [FLEN], input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ b[i][k];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return ~c;
  endfunction

  task automatic build(input int s, input logic [63:0] corr, input logic [15:0] hc, input int seed, input bit bad);
    logic [31:0] f;
    for (int i = 0; i < FLEN; i++) fin[s][i] = 8'(i * 7 + seed);
    fin[s][CSUM] = hc[15:8];
    fin[s][CSUM+1] = hc[7:0];
    for (int i = 0; i < 8; i++) fin[s][CORR+i] = corr[8*(7-i) +: 8];
    f = bench_crc(fin[s], FLEN - 4);
    if (bad) f = ~f;
    for (int i = 0; i < 4; i++) fin[s][FLEN-4+i] = f[8*i +: 8];
  endtask

  task automatic make_exp(input int s, input bit mod, input logic [31:0] rx, input logic [31:0] tx);
    logic [63:0] oc, nc;
    logic [15:0] hc, nh;
    logic [31:0] a, f;
    for (int i = 0; i < FLEN; i++) fexp[s][i] = fin[s][i];
    if (mod) begin
      oc = '0;
      for (int i = 0; i < 8; i++) oc = {oc[55:0], fin[s][CORR+i]};
      nc = oc + ({32'h0, tx - rx} * 64'd5 << 16);
      hc = {fin[s][CSUM], fin[s][CSUM+1]};
      a = {16'h0, ~hc};
      for (int w = 0; w < 4; w++) begin
        a = a + {16'h0, ~oc[16*w +: 16]};
        a = (a & 32'hFFFF) + (a >> 16);
        a = a + {16'h0, nc[16*w +: 16]};
        a = (a & 32'hFFFF) + (a >> 16);
      end
      a = (a & 32'hFFFF) + (a >> 16);
      nh = ~a[15:0];
      if (nh == 16'h0) nh = 16'hFFFF;
      if (hc == 16'h0) nh = 16'h0;
      for (int i = 0; i < 8; i++) fexp[s][CORR+i] = nc[8*(7-i) +: 8];
      fexp[s][CSUM] = nh[15:8];
      fexp[s][CSUM+1] = nh[7:0];
      f = bench_crc(fexp[s], FLEN - 4);
      for (int i = 0; i < 4; i++) fexp[s][FLEN-4+i] = f[8*i +: 8];
    end
  endtask

  task automatic send(input int s, input bit mod, input logic [31:0] rx);
    for (int i = 0; i < FLEN; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == FLEN - 1);
      in_data = fin[s][i]; in_mod = mod; in_rx_ts = rx;
      if (i == 0) cyc_in = cyc;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input int s, input bit mod, input string ctag, input string tail);
    logic [63:0] ac, ec;
    int bad;
    ac = '0; ec = '0; bad = 0;
    for (int i = 0; i < 8; i++) begin ac = {ac[55:0], fout[s][CORR+i]}; ec = {ec[55:0], fexp[s][CORR+i]}; end
    if (!mod) begin
      for (int i = 0; i < FLEN; i++) if (fout[s][i] !== fin[s][i]) bad++;
      chk(bad == 0, {"R8 unmodified frame ", tail}, 64'(bad), 64'd0);
      return;
    end
    chk(ac === ec, {ctag, " correction field ", tail}, ac, ec);
    chk({fout[s][CSUM], fout[s][CSUM+1]} === {fexp[s][CSUM], fexp[s][CSUM+1]},
        (fexp[s][CSUM] == 0 && fexp[s][CSUM+1] == 0) ? {"R6 zero checksum ", tail} : {"R5 checksum ", tail},
        64'({fout[s][CSUM], fout[s][CSUM+1]}), 64'({fexp[s][CSUM], fexp[s][CSUM+1]}));
    chk({fout[s][63], fout[s][62], fout[s][61], fout[s][60]} === {fexp[s][63], fexp[s][62], fexp[s][61], fexp[s][60]},
        {"R7 fcs ", tail}, 64'({fout[s][63], fout[s][62], fout[s][61], fout[s][60]}),
        64'({fexp[s][63], fexp[s][62], fexp[s][61], fexp[s][60]}));
    for (int i = 0; i < FLEN - 4; i++)
      if (!(i >= CORR && i < CORR + 8) && i != CSUM && i != CSUM + 1 && fout[s][i] !== fin[s][i]) bad++;
    chk(bad == 0, {"R1 untouched bytes ", tail}, 64'(bad), 64'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R10 valid low in reset", 64'(out_valid), 64'd0);
    rst_n = 1;
    idle(3);
    chk(out_valid === 1'b0, "R10 valid low after reset", 64'(out_valid), 64'd0);

    for (int v = 0; v < 6; v++) begin
      build(0, VEC[v].corr, VEC[v].hc, v * 13 + 1, !VEC[v].mod);
      make_exp(0, VEC[v].mod, VEC[v].rx, VEC[v].tx);
      tx_ts = VEC[v].tx;
      fo_cnt = 0;
      send(0, VEC[v].mod, VEC[v].rx);
      idle(DEPTH + 6);
      compare(0, VEC[v].mod, (v == 1) ? "R4" : ((v == 0) ? "R2" : "R3"), $sformatf("vector %0d", v));
      if (v == 0) chk(cyc_out - cyc_in == DEPTH + 1, "R1 latency", 64'(cyc_out - cyc_in - 1), 64'(DEPTH));
    end

    // R9: back-to-back frames with different ingress stamps and fields
    build(0, 64'h0000_0000_0001_0000, 16'h2222, 3, 0);
    build(1, 64'h0000_0010_0000_0000, 16'h7777, 9, 0);
    make_exp(0, 1, 32'd100, 32'd2000);
    make_exp(1, 1, 32'd900, 32'd2000);
    tx_ts = 32'd2000;
    fo_cnt = 0;
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < FLEN; i++) begin
        @(negedge clk);
        in_valid = 1; in_sof = (i == 0); in_eof = (i == FLEN - 1);
        in_data = fin[f][i]; in_mod = 1; in_rx_ts = (f == 0) ? 32'd100 : 32'd900;
      end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    idle(DEPTH + 6);
    chk(fo_cnt == 2, "R9 two frames out", 64'(fo_cnt), 64'd2);
    compare(0, 1, "R9", "back-to-back first");
    compare(1, 1, "R9", "back-to-back second");
    finish_run();
  end
endmodule